// File: doc/BRIEF.md
# Bit-Reversed to Natural Order Frame Reorder Buffer

This block sits behind a transform engine that delivers complex results one per clock with the sample index bit-mirrored. It collects each frame and sends it back out in ascending index order. Two frame memories alternate. Arriving samples are stored at the mirrored address, so a frame is complete in memory once its last sample lands. Outgoing samples are then read at plain ascending addresses from the other memory. A new frame can therefore load while the previous one drains.

The frame length is a power of two, chosen at run time as a base-2 exponent. The exponent can be anything from 0 up to the build-time maximum `MAX_LOG2`. Only as many low address bits are mirrored as the chosen exponent; the upper address bits stay zero. A length write takes effect for the next frame whose first sample arrives at least one cycle after the strobe. A frame that is already partly loaded keeps its length. Each memory records the length of the frame it holds, so frames of different lengths can queue back to back.

Both data sides are valid/ready streams. An input sample is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low only while both memories hold frames that have not been fully emitted. `out_valid`, together with its data and `out_last`, stays put until `out_ready` accepts the sample. The producer may drop `in_valid` between samples at any time.

Top module: `brev_reorder`

## Requirements
- R1: Straight after reset, `out_valid` is 0 and `in_ready` is 1. The length exponent resets to `MAX_LOG2`.
- R2: For an 8-point frame (exponent 3), input positions 0..7 carry indices 0,4,2,6,1,5,3,7. The output delivers indices 0..7 in ascending order.
- R3: With exponent k, input position n carries the sample whose index is the k-bit mirror of n; output position i carries index i. This holds for k = 2, k = 1 and k = 0 (a single-sample frame).
- R4: `len_log2` is the base-2 log of the frame length, captured on a clock edge with `len_we` high. A value above `MAX_LOG2` is clamped to `MAX_LOG2`.
- R5: A length write made while a frame is partly loaded does not change that frame. It applies from the next frame.
- R6: `out_last` is 1 on the final output sample of each frame and 0 on every other output sample.
- R7: While one frame is being emitted, the next frame can be loaded. Once two complete frames are held and none has been fully emitted, `in_ready` is 0.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_re`, `out_im` and `out_last` hold their values into the next cycle.
- R9: Frames leave in arrival order, each with the length that was in force when it was loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| len_we | input | 1 | Strobe that captures `len_log2` |
| len_log2 | input | $clog2(MAX_LOG2+1) | Frame length exponent |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Input sample can be taken |
| in_re | input | DW | Input real part |
| in_im | input | DW | Input imaginary part |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Consumer takes the output sample |
| out_re | output | DW | Output real part |
| out_im | output | DW | Output imaginary part |
| out_last | output | 1 | Final sample of a frame |

## Verification
The checker counts a frame as held from the edge that stores its final sample until the edge that hands off its `out_last` sample. It assumes every input is a known value after reset; nothing is assumed about when `in_valid` or `out_ready` toggle. The stimulus drives every input to a defined level from time zero. It changes inputs only on falling edges, pulses `len_we` both between frames and inside a frame, and throttles `out_ready` in a fixed pattern so that the hold rule is exercised.

// File: rtl/brev_pkg.sv
package brev_pkg;
  localparam int ADDR_CAP = 16;

  // Mirror the low k bits of n; bits at or above k come out as zero.
  function automatic logic [ADDR_CAP-1:0] mirror_low(input logic [ADDR_CAP-1:0] n,
                                                     input logic [4:0] k);
    logic [ADDR_CAP-1:0] r;
    int kk;
    r  = '0;
    kk = int'(k);
    for (int i = 0; i < ADDR_CAP; i++) begin
      for (int j = 0; j < ADDR_CAP; j++) begin
        if ((i < kk) && (j == kk - 1 - i)) r[i] = n[j];
      end
    end
    return r;
  endfunction

  // Index of the last sample in a frame of 2^k samples.
  function automatic logic [ADDR_CAP-1:0] last_index(input logic [4:0] k);
    logic [ADDR_CAP-1:0] r;
    for (int i = 0; i < ADDR_CAP; i++) r[i] = (i < int'(k));
    return r;
  endfunction
endpackage

// File: rtl/brev_len_ctrl.sv
module brev_len_ctrl #(
  parameter int MAX_LOG2 = 6,
  parameter int LW = $clog2(MAX_LOG2 + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          len_we,
  input  logic [LW-1:0] len_log2,
  input  logic          wr_idle,
  input  logic          wr_fire,
  output logic [LW-1:0] pend_k,
  output logic [LW-1:0] k_eff
);
  localparam logic [LW-1:0] KMAX = LW'(MAX_LOG2);

  logic [LW-1:0] frame_k;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_k  <= KMAX;
      frame_k <= KMAX;
    end else begin
      if (len_we) pend_k <= (len_log2 > KMAX) ? KMAX : len_log2;
      if (wr_fire && wr_idle) frame_k <= pend_k;
    end
  end

  // The pending value is used for a frame's first sample and kept for the rest of it.
  assign k_eff = wr_idle ? pend_k : frame_k;
endmodule

// File: rtl/brev_wr_side.sv
module brev_wr_side
  import brev_pkg::*;
#(
  parameter int AW = 6,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    bank_full,
  input  logic [LW-1:0] k_eff,
  output logic          in_ready,
  output logic          wr_fire,
  output logic          wr_idle,
  output logic          wr_done,
  output logic          wr_bank,
  output logic [AW-1:0] wr_addr
);
  logic [AW-1:0]       cnt;
  logic [ADDR_CAP-1:0] mir;
  logic [ADDR_CAP-1:0] lastv;

  assign mir      = mirror_low(ADDR_CAP'(cnt), 5'(k_eff));
  assign lastv    = last_index(5'(k_eff));
  assign wr_addr  = mir[AW-1:0];
  assign in_ready = !bank_full[wr_bank];
  assign wr_fire  = in_valid && in_ready;
  assign wr_idle  = (cnt == '0);
  assign wr_done  = wr_fire && (cnt == lastv[AW-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      wr_bank <= 1'b0;
    end else if (wr_done) begin
      cnt     <= '0;
      wr_bank <= !wr_bank;
    end else if (wr_fire) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/brev_rd_side.sv
module brev_rd_side
  import brev_pkg::*;
#(
  parameter int AW = 6,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bank_full,
  input  logic [LW-1:0] rd_k,
  input  logic          out_ready,
  output logic          out_valid,
  output logic          out_last,
  output logic          rd_done,
  output logic          rd_bank,
  output logic [AW-1:0] rd_addr
);
  logic [AW-1:0]       cnt;
  logic [ADDR_CAP-1:0] lastv;
  logic                fire;

  assign lastv     = last_index(5'(rd_k));
  assign out_valid = bank_full[rd_bank];
  assign out_last  = (cnt == lastv[AW-1:0]);
  assign rd_addr   = cnt;
  assign fire      = out_valid && out_ready;
  assign rd_done   = fire && out_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      rd_bank <= 1'b0;
    end else if (rd_done) begin
      cnt     <= '0;
      rd_bank <= !rd_bank;
    end else if (fire) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/brev_bank_mem.sv
module brev_bank_mem #(
  parameter int AW = 6,
  parameter int WW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [WW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [WW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [WW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/brev_reorder.sv
module brev_reorder #(
  parameter int DW = 16,
  parameter int MAX_LOG2 = 6,
  parameter int LW = $clog2(MAX_LOG2 + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          len_we,
  input  logic [LW-1:0] len_log2,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_re,
  input  logic [DW-1:0] in_im,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_re,
  output logic [DW-1:0] out_im,
  output logic          out_last
);
  localparam int AW = MAX_LOG2;
  localparam int WW = 2 * DW;

  logic [1:0]    bank_full;
  logic [LW-1:0] bank_k [2];
  logic [LW-1:0] pend_k, k_eff;
  logic          wr_fire, wr_idle, wr_done, wr_bank;
  logic          rd_done, rd_bank;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [WW-1:0] rdata [2];

  brev_len_ctrl #(.MAX_LOG2(MAX_LOG2), .LW(LW)) u_len (
    .clk(clk), .rst_n(rst_n), .len_we(len_we), .len_log2(len_log2),
    .wr_idle(wr_idle), .wr_fire(wr_fire), .pend_k(pend_k), .k_eff(k_eff)
  );

  brev_wr_side #(.AW(AW), .LW(LW)) u_wr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .bank_full(bank_full),
    .k_eff(k_eff), .in_ready(in_ready), .wr_fire(wr_fire), .wr_idle(wr_idle),
    .wr_done(wr_done), .wr_bank(wr_bank), .wr_addr(wr_addr)
  );

  brev_rd_side #(.AW(AW), .LW(LW)) u_rd (
    .clk(clk), .rst_n(rst_n), .bank_full(bank_full), .rd_k(bank_k[rd_bank]),
    .out_ready(out_ready), .out_valid(out_valid), .out_last(out_last),
    .rd_done(rd_done), .rd_bank(rd_bank), .rd_addr(rd_addr)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    brev_bank_mem #(.AW(AW), .WW(WW)) u_mem (
      .clk(clk), .we(wr_fire && (wr_bank == 1'(b))), .waddr(wr_addr),
      .wdata({in_re, in_im}), .raddr(rd_addr), .rdata(rdata[b])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bank_full[b] <= 1'b0;
        bank_k[b]    <= LW'(MAX_LOG2);
      end else if (wr_done && (wr_bank == 1'(b))) begin
        bank_full[b] <= 1'b1;
        bank_k[b]    <= k_eff;
      end else if (rd_done && (rd_bank == 1'(b))) begin
        bank_full[b] <= 1'b0;
      end
    end
  end

  assign out_re = rdata[rd_bank][WW-1:DW];
  assign out_im = rdata[rd_bank][DW-1:0];
endmodule

// File: rtl/brev_reorder_chk.sv
module brev_reorder_chk #(
  parameter int DW = 16,
  parameter int MAX_LOG2 = 6,
  parameter int LW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_re,
  input logic [DW-1:0] out_im,
  input logic          out_last,
  input logic          wr_done,
  input logic [LW-1:0] pend_k
);
  logic [1:0] held;
  logic       out_end;

  assign out_end = out_valid && out_ready && out_last;

  always_ff @(posedge clk) begin
    if (!rst_n) held <= '0;
    else held <= held + {1'b0, wr_done} - {1'b0, out_end};
  end

  // R7
  hold_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held <= 2'd2);

  // R7
  stall_when_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (held != 2'd2));

  // R1
  valid_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (held != 2'd0));

  // R8
  out_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im)
                                   && $stable(out_last)));

  // R4
  len_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_k <= LW'(MAX_LOG2));
endmodule

bind brev_reorder brev_reorder_chk #(.DW(DW), .MAX_LOG2(MAX_LOG2), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_re(out_re), .out_im(out_im), .out_last(out_last),
  .wr_done(wr_done), .pend_k(pend_k)
);

// File: tb/brev_reorder_tb.sv
`timescale 1ns/1ps
module brev_reorder_tb;
  localparam int DW = 16;
  localparam int MAX_LOG2 = 6;
  localparam int LW = $clog2(MAX_LOG2 + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          len_we = 1'b0;
  logic [LW-1:0] len_log2 = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_re = '0, in_im = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [DW-1:0] out_re, out_im;
  logic          out_last;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  brev_reorder #(.DW(DW), .MAX_LOG2(MAX_LOG2), .LW(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .len_we(len_we), .len_log2(len_log2),
    .in_valid(in_valid), .in_ready(in_ready), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_ready(out_ready), .out_re(out_re),
    .out_im(out_im), .out_last(out_last)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mirror(input int n, input int k);
    int r = 0;
    for (int i = 0; i < k; i++) if (n & (1 << i)) r |= 1 << (k - 1 - i);
    return r;
  endfunction

  function automatic logic [DW-1:0] val_re(input int tag, input int idx);
    return DW'(tag * 256 + idx);
  endfunction

  function automatic logic [DW-1:0] val_im(input int tag, input int idx);
    return ~DW'(tag * 256 + idx);
  endfunction

  task automatic set_len(input int k);
    @(negedge clk);
    len_we = 1'b1;
    len_log2 = LW'(k);
    @(negedge clk);
    len_we = 1'b0;
  endtask

  // Sends a frame in mirrored order; optionally pulses a length write at position poke_at.
  task automatic send_frame(input int k, input int tag, input int poke_at, input int poke_val);
    int n = 1 << k;
    for (int p = 0; p < n; p++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_re = val_re(tag, mirror(p, k));
      in_im = val_im(tag, mirror(p, k));
      len_we = (p == poke_at);
      if (p == poke_at) len_log2 = LW'(poke_val);
      #1;
      while (!in_ready) begin
        @(negedge clk);
        len_we = 1'b0;
        #1;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    len_we = 1'b0;
  endtask

  task automatic recv_frame(input int k, input int tag, input bit stall, input string req);
    int n = 1 << k;
    int i = 0;
    int c = 0;
    int bad = 0, bad_last = 0, bad_hold = 0;
    int first_act = 0, first_exp = 0;
    bit ps = 0;
    logic [DW-1:0] pr = '0;
    while (i < n) begin
      @(negedge clk);
      out_ready = stall ? ((c % 3) != 0) : 1'b1;
      c++;
      #1;
      if (ps && !(out_valid && out_re == pr)) bad_hold++;
      if (out_valid && out_ready) begin
        if (out_re !== val_re(tag, i) || out_im !== val_im(tag, i)) begin
          if (bad == 0) begin first_act = int'(out_re); first_exp = int'(val_re(tag, i)); end
          bad++;
        end
        if (out_last !== (i == n - 1)) bad_last++;
        i++;
        ps = 0;
      end else if (out_valid) begin
        ps = 1;
        pr = out_re;
      end else begin
        ps = 0;
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
    check(bad == 0, req, first_act, first_exp);
    check(bad_last == 0, {req, " R6 last flag"}, bad_last, 0);
    if (stall) check(bad_hold == 0, "R8 hold under back-pressure", bad_hold, 0);
  endtask

  task automatic t_reset;
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
  endtask

  task automatic t_eight;
    set_len(3);
    fork
      send_frame(3, 1, -1, 0);
      recv_frame(3, 1, 1'b0, "R2 eight-point order");
    join
  endtask

  task automatic t_short;
    set_len(2);
    fork
      send_frame(2, 2, -1, 0);
      recv_frame(2, 2, 1'b0, "R3 four-point order");
    join
    set_len(1);
    fork
      send_frame(1, 3, -1, 0);
      recv_frame(1, 3, 1'b0, "R3 two-point order");
    join
    set_len(0);
    fork
      send_frame(0, 4, -1, 0);
      recv_frame(0, 4, 1'b0, "R3 single-sample frame");
    join
  endtask

  task automatic t_clamp;
    set_len(7);
    fork
      send_frame(6, 5, -1, 0);
      recv_frame(6, 5, 1'b1, "R4 clamped 64-point frame");
    join
  endtask

  task automatic t_midframe;
    set_len(3);
    fork
      send_frame(3, 6, 3, 2);
      recv_frame(3, 6, 1'b0, "R5 frame keeps length");
    join
    fork
      send_frame(2, 7, -1, 0);
      recv_frame(2, 7, 1'b0, "R5 next frame uses new length");
    join
  endtask

  task automatic t_pingpong;
    out_ready = 1'b0;
    set_len(3);
    send_frame(3, 8, -1, 0);
    set_len(2);
    send_frame(2, 9, -1, 0);
    repeat (2) @(negedge clk);
    #1;
    check(in_ready == 1'b0, "R7 stall with two frames held", in_ready, 0);
    check(out_valid == 1'b1, "R7 output pending", out_valid, 1);
    recv_frame(3, 8, 1'b0, "R9 first queued frame");
    #1;
    check(in_ready == 1'b1, "R7 ready after one frame drained", in_ready, 1);
    fork
      send_frame(2, 10, -1, 0);
      recv_frame(2, 9, 1'b1, "R9 second queued frame, own length");
    join
    recv_frame(2, 10, 1'b0, "R7 frame loaded during unload");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_eight();
    t_short();
    t_clamp();
    t_midframe();
    t_pingpong();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule